// File: doc/BRIEF.md
# Multi-Mode Capture, Compare and PWM Unit

This peripheral holds one 16-bit data register and switches it between three jobs under the control of a 4-bit mode code. In capture mode it copies a free-running 16-bit timer into the data register when the input pin shows a chosen edge, or every 4th or 16th rising edge. In compare mode it watches the same timer for equality with the data register. On a match it drives the output pin high or low, only raises the interrupt flag, or also sends a one-cycle pulse that restarts the timer. In PWM mode it produces a pulse train against an 8-bit period timer, with a 10-bit duty value.

Software reaches the unit through three byte registers: control, data low byte and data high byte. Writes take effect at the clock edge. Reads are combinational from the selected address. The 16-bit timer, the period timer and its restart strobe come from outside the block. The interrupt flag stays set until the clear input is pulsed.

Top module: `ccp_unit`

## Requirements
- R1: After reset, every register reads 0 and pinOut, intFlag and specialEvent are low. Address 0 is control, address 1 is the data low byte, address 2 is the data high byte, and address 3 reads 0.
- R2: Control bits 7:6 always read 0. Control bits 5:0 and both data bytes read back what was last written. In the control byte, bits 3:0 hold the mode code and bits 5:4 hold the duty LSBs.
- R3: Mode 0000 holds pinOut low and never sets the flag. While in this mode it clears the compare pin state, the capture prescaler and the PWM duty shadow.
- R4: Mode 0100 captures on a falling capIn edge and mode 0101 captures on a rising edge. The edge is the first clock edge at which capIn differs from its value at the previous clock edge. At that clock edge the data register takes the timerCount value and intFlag is set. A capture wins over a data-byte write in the same cycle.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge.
- R6: A match starts in the first cycle in which a compare mode (10xx) is active and timerCount equals the data register. On a match start, mode 1000 drives pinOut high and mode 1001 drives it low, and both set intFlag.
- R7: Mode 1010 sets intFlag on a match start and leaves pinOut at its previous level.
- R8: Mode 1011 sets intFlag on a match start. In the following cycle it raises specialEvent for exactly one cycle.
- R9: Modes 11xx give PWM. The duty is {low byte, control bits 5:4}. pinOut is high while {periodCount, fine} is below the duty shadow, where fine is a 2-bit count that advances every clock and returns to 0 on periodRestart.
- R10: The duty shadow loads only at a clock edge with periodRestart high. A duty write in mid-period does not change the waveform until the next restart.
- R11: A control write that changes the mode code clears the capture prescaler, so the 4th or 16th edge count starts again.
- R12: A pulse on intClear clears intFlag. If a capture or match start happens in the same cycle, intFlag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 control, 1 low, 2 high) |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data, combinational |
| capIn | input | 1 | External capture input |
| timerCount | input | 16 | 16-bit timer count |
| periodCount | input | 8 | Period timer count |
| periodRestart | input | 1 | Period restart strobe |
| intClear | input | 1 | Clears the interrupt flag |
| pinOut | output | 1 | Output pin |
| intFlag | output | 1 | Interrupt flag |
| specialEvent | output | 1 | One-cycle timer reset pulse |

## Verification
The hardest case to reach is a prescaler restart. The bench must leave the every-4th counter partway through its count and then change the mode. Only the count of edges needed before the next capture shows whether the counter was cleared. The stimulus gives three rising edges and then toggles the mode away and back. It then shows that three more edges capture nothing while the fourth does. A duty write in mid-period is reached by waiting for the pin to go high just after a restart and writing a zero duty at once. The pin must stay high until the restart that follows.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int DATA_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int MODE_W  = 4;
  localparam int FINE_W  = 2;
  localparam int PER_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int CTRL_W  = 6;
  localparam int DUTY_W  = PER_W + FINE_W;
  localparam int PRES_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd2;

  localparam logic [MODE_W-1:0] M_OFF     = 4'b0000;
  localparam logic [MODE_W-1:0] M_CAP_FALL = 4'b0100;
  localparam logic [MODE_W-1:0] M_CAP_RISE = 4'b0101;
  localparam logic [MODE_W-1:0] M_CAP_4   = 4'b0110;
  localparam logic [MODE_W-1:0] M_CAP_16  = 4'b0111;
  localparam logic [MODE_W-1:0] M_CMP_SET = 4'b1000;
  localparam logic [MODE_W-1:0] M_CMP_CLR = 4'b1001;
  localparam logic [MODE_W-1:0] M_CMP_FLAG = 4'b1010;
  localparam logic [MODE_W-1:0] M_CMP_EVT = 4'b1011;

  typedef struct packed {
    logic capture;
    logic matchEvt;
    logic setPin;
    logic clrPin;
    logic fireEvent;
    logic offClear;
    logic wrLow;
    logic wrHigh;
  } ccp_strobe_t;

  function automatic logic isCompare(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b10;
  endfunction

  function automatic logic isPwm(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b11;
  endfunction
endpackage

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
  import ccp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CTRL_W-1:0]   ctrlWrData,
  input  logic                capIn,
  input  logic [DATA_W-1:0]   timerCount,
  input  logic [DATA_W-1:0]   dataReg,
  output logic [CTRL_W-1:0]   ctrlReg,
  output ccp_strobe_t         strb
);
  logic [MODE_W-1:0] mode;
  logic              wrCtrl;
  logic              modeChange;
  logic              capPrev;
  logic              riseSeen;
  logic              fallSeen;
  logic [PRES_W-1:0] presCnt;
  logic [PRES_W-1:0] presLimit;
  logic              prescaled;
  logic              capHit;
  logic              match;
  logic              matchPrev;
  logic              matchEvt;

  assign mode       = ctrlReg[MODE_W-1:0];
  assign wrCtrl     = wrEn && (wrAddr == ADDR_CTRL);
  assign modeChange = wrCtrl && (ctrlWrData[MODE_W-1:0] != mode);
  assign riseSeen   = capIn && !capPrev;
  assign fallSeen   = !capIn && capPrev;
  assign prescaled  = (mode == M_CAP_4) || (mode == M_CAP_16);
  assign presLimit  = (mode == M_CAP_4) ? PRES_W'(3) : PRES_W'(15);

  always_comb begin
    case (mode)
      M_CAP_FALL: capHit = fallSeen;
      M_CAP_RISE: capHit = riseSeen;
      M_CAP_4,
      M_CAP_16:   capHit = riseSeen && (presCnt == presLimit);
      default:    capHit = 1'b0;
    endcase
  end

  assign match    = isCompare(mode) && (timerCount == dataReg);
  assign matchEvt = match && !matchPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      capPrev   <= 1'b0;
      presCnt   <= '0;
      matchPrev <= 1'b0;
    end else begin
      capPrev   <= capIn;
      matchPrev <= match;
      if (wrCtrl) ctrlReg <= ctrlWrData;
      if (mode == M_OFF || modeChange)
        presCnt <= '0;
      else if (prescaled && riseSeen)
        presCnt <= (presCnt == presLimit) ? '0 : presCnt + PRES_W'(1);
    end
  end

  always_comb begin
    strb           = '0;
    strb.capture   = capHit;
    strb.matchEvt  = matchEvt;
    strb.setPin    = matchEvt && (mode == M_CMP_SET);
    strb.clrPin    = matchEvt && (mode == M_CMP_CLR);
    strb.fireEvent = matchEvt && (mode == M_CMP_EVT);
    strb.offClear  = (mode == M_OFF);
    strb.wrLow     = wrEn && (wrAddr == ADDR_LOW);
    strb.wrHigh    = wrEn && (wrAddr == ADDR_HIGH);
  end

  // R11: a mode change restarts the prescaler
  a_r11_pres_restart: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |=> presCnt == '0);
  // R5: the every-4th count never passes its limit
  a_r5_pres_bound: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_CAP_4) |-> presCnt < PRES_W'(4));
  // R6: a match start fires once per equality run
  a_r6_single_match: assert property (@(posedge clk) disable iff (!rstN)
    strb.matchEvt |=> !strb.matchEvt);
endmodule

// File: rtl/ccp_datapath.sv
module ccp_datapath
  import ccp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ccp_strobe_t         strb,
  input  logic [CTRL_W-1:0]   ctrlReg,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   timerCount,
  input  logic [PER_W-1:0]    periodCount,
  input  logic                periodRestart,
  input  logic                intClear,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [BYTE_W-1:0]   rdData,
  output logic [DATA_W-1:0]   dataReg,
  output logic                pinOut,
  output logic                intFlag,
  output logic                specialEvent
);
  localparam int LSB_W = CTRL_W - MODE_W;

  logic [MODE_W-1:0] mode;
  logic [LSB_W-1:0]  dutyLsb;
  logic              pinLatch;
  logic [FINE_W-1:0] fine;
  logic [DUTY_W-1:0] shadow;
  logic [DUTY_W-1:0] extCount;
  logic              pwmHigh;

  assign mode     = ctrlReg[MODE_W-1:0];
  assign dutyLsb  = ctrlReg[CTRL_W-1:MODE_W];
  assign extCount = {periodCount, fine};
  assign pwmHigh  = extCount < shadow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg      <= '0;
      intFlag      <= 1'b0;
      pinLatch     <= 1'b0;
      specialEvent <= 1'b0;
      fine         <= '0;
      shadow       <= '0;
    end else begin
      if (strb.capture)
        dataReg <= timerCount;
      else begin
        if (strb.wrLow)  dataReg[BYTE_W-1:0]      <= wrData;
        if (strb.wrHigh) dataReg[DATA_W-1:BYTE_W] <= wrData;
      end

      if (strb.capture || strb.matchEvt) intFlag <= 1'b1;
      else if (intClear)                 intFlag <= 1'b0;

      if (strb.offClear)    pinLatch <= 1'b0;
      else if (strb.setPin) pinLatch <= 1'b1;
      else if (strb.clrPin) pinLatch <= 1'b0;

      specialEvent <= strb.fireEvent;

      fine <= periodRestart ? '0 : fine + FINE_W'(1);

      if (strb.offClear)   shadow <= '0;
      else if (periodRestart) shadow <= {dataReg[BYTE_W-1:0], dutyLsb};
    end
  end

  always_comb begin
    if (isPwm(mode))          pinOut = pwmHigh;
    else if (isCompare(mode)) pinOut = pinLatch;
    else                      pinOut = 1'b0;
  end

  always_comb begin
    case (rdAddr)
      ADDR_CTRL: rdData = {{(BYTE_W-CTRL_W){1'b0}}, ctrlReg};
      ADDR_LOW:  rdData = dataReg[BYTE_W-1:0];
      ADDR_HIGH: rdData = dataReg[DATA_W-1:BYTE_W];
      default:   rdData = '0;
    endcase
  end

  // R4: a capture stores the timer sampled at that edge
  a_r4_capture_loads: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> dataReg == $past(timerCount));
  // R12: a set event always leaves the flag high
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture || strb.matchEvt) |=> intFlag);
  // R10: the duty shadow only moves on a restart or while off
  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!periodRestart && !strb.offClear) |=> $stable(shadow));
  // R7: with no set or clear the pin state is kept
  a_r7_pin_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setPin && !strb.clrPin && !strb.offClear) |=> $stable(pinLatch));
  // R8: the timer reset pulse lasts one cycle
  a_r8_event_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    specialEvent |=> !specialEvent);
  // R3: off mode keeps the pin low
  a_r3_off_pin_low: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_OFF) |-> !pinOut);
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [BYTE_W-1:0]   rdData,
  input  logic                capIn,
  input  logic [DATA_W-1:0]   timerCount,
  input  logic [PER_W-1:0]    periodCount,
  input  logic                periodRestart,
  input  logic                intClear,
  output logic                pinOut,
  output logic                intFlag,
  output logic                specialEvent
);
  ccp_strobe_t       strb;
  logic [CTRL_W-1:0] ctrlReg;
  logic [DATA_W-1:0] dataReg;

  ccp_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .ctrlWrData (wrData[CTRL_W-1:0]),
    .capIn      (capIn),
    .timerCount (timerCount),
    .dataReg    (dataReg),
    .ctrlReg    (ctrlReg),
    .strb       (strb)
  );

  ccp_datapath dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .ctrlReg       (ctrlReg),
    .wrData        (wrData),
    .timerCount    (timerCount),
    .periodCount   (periodCount),
    .periodRestart (periodRestart),
    .intClear      (intClear),
    .rdAddr        (rdAddr),
    .rdData        (rdData),
    .dataReg       (dataReg),
    .pinOut        (pinOut),
    .intFlag       (intFlag),
    .specialEvent  (specialEvent)
  );
endmodule

// File: tb/ccp_unit_tb_top.sv
`timescale 1ns/1ps
module ccp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        capIn = 1'b0;
  logic [15:0] timerCount = '0;
  logic [7:0]  periodCount = '0;
  logic        periodRestart = 1'b0;
  logic        intClear = 1'b0;
  logic        pinOut, intFlag, specialEvent;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ccp_unit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .capIn(capIn), .timerCount(timerCount),
    .periodCount(periodCount), .periodRestart(periodRestart), .intClear(intClear),
    .pinOut(pinOut), .intFlag(intFlag), .specialEvent(specialEvent)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // timer and period stimulus
  logic [15:0] tmr = '0;
  int ph = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      tmr = '0; ph = 0;
    end else begin
      if (specialEvent) tmr = '0; else tmr = tmr + 16'd1;
      ph = (ph + 1) % 32;
    end
    timerCount    = tmr;
    periodCount   = 8'(ph / 4);
    periodRestart = (ph == 31);
  end

  // behavioural reference model
  int mCtrl, mData, mFlag, mPin, mCapPrev, mPres, mMatchPrev, mEvt, mShadow, mFine;
  always @(posedge clk) begin
    int m, lim, nCtrl, nData;
    bit rise, fall, capt, match, mev;
    if (!rstN) begin
      mCtrl = 0; mData = 0; mFlag = 0; mPin = 0; mCapPrev = 0; mPres = 0;
      mMatchPrev = 0; mEvt = 0; mShadow = 0; mFine = 0;
    end else begin
      m = mCtrl % 16;
      rise = capIn && !mCapPrev;
      fall = !capIn && mCapPrev;
      lim = (m == 6) ? 4 : 16;
      capt = 0;
      if (m == 4) capt = fall;
      if (m == 5) capt = rise;
      if ((m == 6 || m == 7) && rise) begin
        if (mPres + 1 == lim) begin capt = 1; mPres = 0; end
        else mPres = mPres + 1;
      end
      match = (m >= 8 && m <= 11) && (int'(timerCount) == mData);
      mev = match && !mMatchPrev;
      nCtrl = mCtrl;
      if (wrEn && wrAddr == 0) begin
        nCtrl = wrData % 64;
        if (nCtrl % 16 != m) mPres = 0;
      end
      if (m == 0) mPres = 0;
      nData = mData;
      if (capt) nData = timerCount;
      else begin
        if (wrEn && wrAddr == 1) nData = (mData & 16'hFF00) | wrData;
        if (wrEn && wrAddr == 2) nData = (mData & 16'h00FF) | (int'(wrData) << 8);
      end
      if (capt || mev) mFlag = 1; else if (intClear) mFlag = 0;
      if (m == 0) mPin = 0; else if (mev && m == 8) mPin = 1; else if (mev && m == 9) mPin = 0;
      mEvt = mev && m == 11;
      if (m == 0) mShadow = 0;
      else if (periodRestart) mShadow = ((mData % 256) * 4) + (mCtrl / 16);
      mFine = periodRestart ? 0 : (mFine + 1) % 4;
      mCapPrev = capIn;
      mMatchPrev = match;
      mCtrl = nCtrl;
      mData = nData;
    end
  end

  function automatic string tagFor(input int m);
    if (m == 0) return "R3";
    if (m < 6) return "R4";
    if (m < 8) return "R5";
    if (m < 10) return "R6";
    if (m == 10) return "R7";
    if (m == 11) return "R8";
    return "R9";
  endfunction

  always @(posedge clk) begin
    #2;
    if (rstN) begin
      int m, expPin, expRd;
      m = mCtrl % 16;
      if (m >= 12) expPin = ((int'(periodCount) * 4 + mFine) < mShadow) ? 1 : 0;
      else if (m >= 8) expPin = mPin;
      else expPin = 0;
      case (rdAddr)
        2'd0: expRd = mCtrl;
        2'd1: expRd = mData % 256;
        2'd2: expRd = mData / 256;
        default: expRd = 0;
      endcase
      check(pinOut == expPin, {tagFor(m), " pinOut"}, pinOut, expPin);
      check(intFlag == mFlag, {tagFor(m), " intFlag"}, intFlag, mFlag);
      check(specialEvent == mEvt, {tagFor(m), " specialEvent"}, specialEvent, mEvt);
      check(int'(rdData) == expRd, {tagFor(m), " rdData"}, rdData, expRd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); rdAddr = a; #1 v = rdData;
  endtask

  task automatic edge_in(input logic v);
    @(negedge clk); capIn = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk); intClear = 1'b1;
    @(negedge clk); intClear = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin edge_in(1'b1); edge_in(1'b0); end
  endtask

  initial begin
    int v, cmpAt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check(v == 0, "R1 reset read", v, 0);
    end
    check(!pinOut && !intFlag && !specialEvent, "R1 reset outputs", {pinOut, intFlag, specialEvent}, 0);
    // R2 readback
    wr(2'd0, 8'hFF); rd(2'd0, v); check(v == 8'h3F, "R2 ctrl top bits", v, 8'h3F);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hA5); wr(2'd2, 8'h5A);
    rd(2'd1, v); check(v == 8'hA5, "R2 low byte", v, 8'hA5);
    rd(2'd2, v); check(v == 8'h5A, "R2 high byte", v, 8'h5A);
    // R4 rising and falling capture
    wr(2'd0, 8'h05); edge_in(1'b1);
    check(intFlag == 1, "R4 rising capture flag", intFlag, 1);
    clearFlag(); check(intFlag == 0, "R12 clear flag", intFlag, 0);
    edge_in(1'b0); check(intFlag == 0, "R4 falling ignored in rising mode", intFlag, 0);
    wr(2'd0, 8'h04); edge_in(1'b1); edge_in(1'b0);
    check(intFlag == 1, "R4 falling capture flag", intFlag, 1);
    clearFlag();
    // R5 every 4th
    wr(2'd0, 8'h06); pulses(3);
    check(intFlag == 0, "R5 no capture before 4th", intFlag, 0);
    pulses(1); check(intFlag == 1, "R5 capture on 4th", intFlag, 1);
    clearFlag();
    // R11 prescaler restart
    pulses(3); wr(2'd0, 8'h07); wr(2'd0, 8'h06); pulses(3);
    check(intFlag == 0, "R11 count restarted after mode change", intFlag, 0);
    pulses(1); check(intFlag == 1, "R11 capture on new 4th", intFlag, 1);
    clearFlag();
    // R5 every 16th
    wr(2'd0, 8'h07); pulses(15);
    check(intFlag == 0, "R5 no capture before 16th", intFlag, 0);
    pulses(1); check(intFlag == 1, "R5 capture on 16th", intFlag, 1);
    wr(2'd0, 8'h00); clearFlag();
    // R6 compare set / clear
    cmpAt = int'(tmr) + 40;
    wr(2'd1, 8'(cmpAt)); wr(2'd2, 8'(cmpAt >> 8)); wr(2'd0, 8'h08);
    repeat (45) @(negedge clk);
    check(pinOut == 1, "R6 compare set pin", pinOut, 1);
    check(intFlag == 1, "R6 compare flag", intFlag, 1);
    clearFlag();
    cmpAt = int'(tmr) + 40;
    wr(2'd1, 8'(cmpAt)); wr(2'd2, 8'(cmpAt >> 8)); wr(2'd0, 8'h09);
    repeat (45) @(negedge clk);
    check(pinOut == 0, "R6 compare clear pin", pinOut, 0);
    clearFlag();
    cmpAt = int'(tmr) + 40;
    wr(2'd1, 8'(cmpAt)); wr(2'd2, 8'(cmpAt >> 8)); wr(2'd0, 8'h08);
    repeat (45) @(negedge clk); clearFlag();
    // R7 flag only
    cmpAt = int'(tmr) + 40;
    wr(2'd1, 8'(cmpAt)); wr(2'd2, 8'(cmpAt >> 8)); wr(2'd0, 8'h0A);
    repeat (45) @(negedge clk);
    check(intFlag == 1, "R7 flag on match", intFlag, 1);
    check(pinOut == 1, "R7 pin unchanged", pinOut, 1);
    clearFlag();
    // R8 special event
    cmpAt = int'(tmr) + 30;
    wr(2'd1, 8'(cmpAt)); wr(2'd2, 8'(cmpAt >> 8)); wr(2'd0, 8'h0B);
    v = 0;
    for (int i = 0; i < 60 && !specialEvent; i++) @(negedge clk);
    check(specialEvent == 1, "R8 event pulse seen", specialEvent, 1);
    @(negedge clk);
    check(specialEvent == 0, "R8 event one cycle", specialEvent, 0);
    wr(2'd0, 8'h00); clearFlag();
    // R9 PWM duty 10 = {0x02, 2'b10}
    wr(2'd1, 8'h02); wr(2'd0, 8'h2C);
    repeat (100) @(negedge clk);
    // R10 mid-period write held until restart
    wr(2'd1, 8'h05); wr(2'd0, 8'h0C);
    repeat (70) @(negedge clk);
    while (!periodRestart) @(negedge clk);
    @(negedge clk); @(negedge clk);
    check(pinOut == 1, "R10 pin high early in period", pinOut, 1);
    wr(2'd1, 8'h00);
    check(pinOut == 1, "R10 duty write not yet applied", pinOut, 1);
    while (!periodRestart) @(negedge clk);
    repeat (3) @(negedge clk);
    check(pinOut == 0, "R10 zero duty after restart", pinOut, 0);
    // R3 off
    wr(2'd1, 8'h10); wr(2'd0, 8'h00);
    repeat (40) @(negedge clk);
    check(pinOut == 0 && intFlag == 0, "R3 off mode quiet", {pinOut, intFlag}, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule